// File: doc/BRIEF.md
# Integer-to-Float Tile Row Converter

This block holds a small two-dimensional tile of 32-bit words (by default 16 rows of 64 bytes) and, on request, reads one 64-byte chunk of one row. It converts each of the 16 signed 32-bit integers in that chunk to an IEEE single-precision value and returns them together as a 512-bit vector.

A 32-bit selector word comes with each request. Its lower half picks the row, and its upper half picks the chunk, counted in 64-byte steps. Two configuration inputs describe the tile shape that is currently in use: a row count and a column-byte count. Any lane that lies at or beyond the column-byte limit returns zero. A row outside the configured row count returns a vector of all zeros.

Rounding is always to nearest, with ties going to even, and no exception information is produced. Tile contents are loaded one whole row at a time through a plain write port. The result is registered.

Top module: `i2f_tile_row`

## Requirements
- R1: After synchronous reset, `out_valid` is 0, `out_vec` is all zeros and every tile row reads as zero.
- R2: `out_valid` is high in exactly the cycle after each cycle in which `req_valid` is high, and low otherwise.
- R3: The row index is `req_sel[15:0]`. If it is at or above `cfg_rows` (or above the physical row count), every bit of the result is 0.
- R4: The chunk number is `req_sel[31:16]`. Lane i, held in `out_vec[32*i+31:32*i]`, is zero when 16*chunk + i is at least `cfg_colsb`/4 (integer division). Any non-zero chunk therefore zeroes every lane.
- R5: A valid lane i holds the fp32 conversion of the two's-complement integer in bits [32*i+31:32*i] of the selected row. The conversion is exact when the magnitude is no more than 2^24.
- R6: Magnitudes above 2^24 round to the nearest representable value, and an exact tie goes to the even mantissa. For example, 16777217 gives 0x4B800000, 16777219 gives 0x4B800002, and 2147483647 gives 0x4F000000.
- R7: Integer 0 converts to +0.0 (0x00000000), and -2147483648 converts to 0xCF000000.
- R8: When `wr_en` is high, `wr_data` is stored into row `wr_row` at the clock edge. A request made in any later cycle reads the new contents.
- R9: While `req_valid` is low, `out_vec` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Row write strobe |
| wr_row | input | 4 | Row written |
| wr_data | input | 512 | Row contents, lane i at bits 32*i+31:32*i |
| cfg_rows | input | 5 | Configured row count (0..16) |
| cfg_colsb | input | 7 | Configured bytes per row (0..64) |
| req_valid | input | 1 | Conversion request strobe |
| req_sel | input | 32 | Selector: [15:0] row, [31:16] chunk |
| out_valid | output | 1 | Result valid, one cycle after request |
| out_vec | output | 512 | 16 converted fp32 lanes |

## Verification
The hardest case to reach from the ports is an exact rounding tie above 2^24. Random integers land on a tie with guard set and sticky clear only rarely, and a tie whose kept LSB decides the direction is rarer still. A directed row therefore loads tie values on both the even and odd side, values just above and below a tie, the extreme integers and zero. Random rows, column limits, row counts and chunks then cover the lane masking.

// File: rtl/i2f_row_pkg.sv
package i2f_row_pkg;

    typedef logic [31:0] word_t;

    typedef struct packed {
        logic        sign;
        logic [7:0]  expo;
        logic [22:0] frac;
    } fp32_t;

    // Signed 32-bit integer to single precision, round to nearest even.
    function automatic fp32_t int_to_fp32(input word_t v);
        word_t       mag;
        word_t       low_mask;
        int          msb;
        int          sh;
        logic [23:0] kept;
        logic        guard;
        logic        sticky;
        logic [30:0] body;
        fp32_t       res;
        mag      = v[31] ? (~v + 32'd1) : v;
        msb      = 0;
        kept     = '0;
        guard    = 1'b0;
        sticky   = 1'b0;
        low_mask = '0;
        for (int b = 0; b < 32; b++) begin
            if (mag[b]) msb = b;
        end
        if (msb <= 23) begin
            kept = 24'(mag << (23 - msb));
        end else begin
            sh       = msb - 23;
            kept     = 24'(mag >> sh);
            guard    = mag[sh-1];
            low_mask = (32'd1 << (sh - 1)) - 32'd1;
            sticky   = |(mag & low_mask);
        end
        // carry out of the fraction bumps the exponent naturally
        body = {8'(127 + msb), kept[22:0]};
        body = body + 31'(guard && (sticky || kept[0]));
        res  = fp32_t'({v[31], body});
        if (mag == '0) res = '0;
        return res;
    endfunction

endpackage

// File: rtl/i2f_tile_store.sv
module i2f_tile_store #(
    parameter int ROWS  = 16,
    parameter int ROW_W = 512,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [ROW_W-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [ROW_W-1:0] rd_data
);
    logic [ROW_W-1:0] rows_q [ROWS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < ROWS; r++) rows_q[r] <= '0;
        end else if (wr_en && (32'(wr_idx) < ROWS)) begin
            rows_q[wr_idx] <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        if (32'(rd_idx) < ROWS) rd_data = rows_q[rd_idx];
    end
endmodule

// File: rtl/i2f_lane.sv
module i2f_lane
    import i2f_row_pkg::*;
(
    input  word_t int_in,
    input  logic  keep,
    output word_t fp_out
);
    fp32_t conv;

    always_comb begin
        conv   = int_to_fp32(int_in);
        fp_out = keep ? word_t'(conv) : '0;
    end

    always_comb begin
        // R7: zero input yields positive zero
        if (keep && int_in == '0) a_r7_zero_is_plus_zero: assert (fp_out == '0);
        // R5: sign carried through for non-zero inputs
        if (keep && int_in != '0) a_r5_sign_kept: assert (fp_out[31] == int_in[31]);
    end
endmodule

// File: rtl/i2f_tile_row.sv
module i2f_tile_row
    import i2f_row_pkg::*;
#(
    parameter int ROWS      = 16,
    parameter int ROW_BYTES = 64
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                wr_en,
    input  logic [$clog2(ROWS)-1:0]             wr_row,
    input  logic [ROW_BYTES*8-1:0]              wr_data,
    input  logic [$clog2(ROWS+1)-1:0]           cfg_rows,
    input  logic [$clog2(ROW_BYTES+1)-1:0]      cfg_colsb,
    input  logic                                req_valid,
    input  logic [31:0]                         req_sel,
    output logic                                out_valid,
    output logic [ROW_BYTES*8-1:0]              out_vec
);
    localparam int LANES = ROW_BYTES / 4;
    localparam int ROW_W = ROW_BYTES * 8;
    localparam int IDX_W = $clog2(ROWS);
    localparam int CB_W  = $clog2(ROW_BYTES + 1);

    logic [15:0]      row_sel;
    logic [15:0]      chunk;
    logic             row_ok;
    logic [CB_W-1:0]  lane_lim;
    logic [ROW_W-1:0] row_data;
    logic [ROW_W-1:0] conv_vec;

    assign row_sel  = req_sel[15:0];
    assign chunk    = req_sel[31:16];
    assign row_ok   = (row_sel < 16'(cfg_rows)) && (32'(row_sel) < ROWS);
    assign lane_lim = cfg_colsb >> 2;

    i2f_tile_store #(.ROWS(ROWS), .ROW_W(ROW_W), .IDX_W(IDX_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_row),
        .wr_data (wr_data),
        .rd_idx  (row_sel[IDX_W-1:0]),
        .rd_data (row_data)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [31:0] pos;
        logic        keep;
        word_t       lane_out;
        assign pos  = 32'(chunk) * 32'(LANES) + 32'(i);
        assign keep = row_ok && (pos < 32'(lane_lim)) && (pos < 32'(LANES));
        i2f_lane u_lane (
            .int_in (row_data[i*32 +: 32]),
            .keep   (keep),
            .fp_out (lane_out)
        );
        assign conv_vec[i*32 +: 32] = lane_out;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_vec   <= '0;
        end else begin
            out_valid <= req_valid;
            if (req_valid) out_vec <= conv_vec;
        end
    end

    a_r2_valid_follows_req: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_valid);
    a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !out_valid);
    a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(out_vec));
    a_r3_bad_row_zero: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !(req_sel[15:0] < 16'(cfg_rows))) |=> (out_vec == '0));
    a_r4_far_chunk_zero: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_sel[31:16] != 16'd0) |=> (out_vec == '0));
endmodule

// File: tb/i2f_tile_row_test.sv
module i2f_tile_row_test;
    logic         clk = 1'b0;
    logic         rst;
    logic         wr_en;
    logic [3:0]   wr_row;
    logic [511:0] wr_data;
    logic [4:0]   cfg_rows;
    logic [6:0]   cfg_colsb;
    logic         req_valid;
    logic [31:0]  req_sel;
    logic         out_valid;
    logic [511:0] out_vec;

    int n_checks = 0;
    int n_fail   = 0;
    logic [511:0] model [16];
    int unsigned seed = 32'd20240611;

    always #2 clk = ~clk;

    i2f_tile_row uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_row(wr_row), .wr_data(wr_data),
        .cfg_rows(cfg_rows), .cfg_colsb(cfg_colsb), .req_valid(req_valid),
        .req_sel(req_sel), .out_valid(out_valid), .out_vec(out_vec)
    );

    // Reference conversion through double precision, then RNE to single.
    function automatic logic [31:0] ref_cvt(input logic [31:0] x);
        real         r;
        logic [63:0] d;
        logic [22:0] fm;
        logic [28:0] rem;
        int          e;
        logic        up;
        if (x == 32'd0) return 32'd0;
        r   = $itor($signed(x));
        d   = $realtobits(r);
        e   = int'(d[62:52]) - 1023 + 127;
        fm  = d[51:29];
        rem = d[28:0];
        up  = (rem > 29'h10000000) || (rem == 29'h10000000 && fm[0]);
        return {d[63], 8'(e), fm} + 32'(up);
    endfunction

    function automatic logic [511:0] ref_vec(input logic [31:0] sel);
        logic [511:0] v = '0;
        int row = int'(sel[15:0]);
        int ch  = int'(sel[31:16]);
        if (row >= int'(cfg_rows) || row >= 16) return v;
        for (int i = 0; i < 16; i++) begin
            if (ch * 16 + i < int'(cfg_colsb) / 4)
                v[i*32 +: 32] = ref_cvt(model[row][i*32 +: 32]);
        end
        return v;
    endfunction

    task automatic check(input string req, input logic [511:0] act, input logic [511:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_row(input int r, input logic [511:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_row = 4'(r); wr_data = d;
        model[r] = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic request(input string req, input logic [31:0] sel);
        logic [511:0] exp;
        @(negedge clk);
        req_valid = 1'b1; req_sel = sel;
        exp = ref_vec(sel);
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " R2 valid"}, {511'd0, out_valid}, 512'd1);
        check(req, out_vec, exp);
    endtask

    initial begin
        logic [511:0] d;
        logic [511:0] held;
        rst = 1'b1; wr_en = 0; wr_row = 0; wr_data = '0;
        cfg_rows = 5'd16; cfg_colsb = 7'd64; req_valid = 0; req_sel = '0;
        for (int r = 0; r < 16; r++) model[r] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1 out_valid", {511'd0, out_valid}, 512'd0);
        check("R1 out_vec", out_vec, '0);
        request("R1 row reads zero", 32'h0000_0005);

        // R6/R7/R5 directed values in row 3
        d = '0;
        d[0*32 +: 32]  = 32'd0;
        d[1*32 +: 32]  = 32'h8000_0000;
        d[2*32 +: 32]  = 32'h7FFF_FFFF;
        d[3*32 +: 32]  = 32'd16777217;
        d[4*32 +: 32]  = 32'd16777219;
        d[5*32 +: 32]  = 32'd16777218;
        d[6*32 +: 32]  = 32'hFFFF_FFFF;
        d[7*32 +: 32]  = 32'd1;
        d[8*32 +: 32]  = 32'd16777216;
        d[9*32 +: 32]  = -32'sd16777217;
        d[10*32 +: 32] = 32'd33554438;
        d[11*32 +: 32] = 32'd33554437;
        d[12*32 +: 32] = 32'd33554439;
        d[13*32 +: 32] = 32'h0000_0300;
        d[14*32 +: 32] = -32'sd123456789;
        d[15*32 +: 32] = 32'h0FFF_FFFF;
        write_row(3, d);
        request("R6 R7 R8 directed row", 32'h0000_0003);
        check("R7 zero", {480'd0, out_vec[31:0]}, 512'h0);
        check("R7 most negative", {480'd0, out_vec[63:32]}, 512'hCF00_0000);
        check("R6 max positive", {480'd0, out_vec[95:64]}, 512'h4F00_0000);
        check("R6 tie even down", {480'd0, out_vec[127:96]}, 512'h4B80_0000);
        check("R6 tie odd up", {480'd0, out_vec[159:128]}, 512'h4B80_0002);
        check("R5 minus one", {480'd0, out_vec[223:192]}, 512'hBF80_0000);

        // R9: output holds while idle
        held = out_vec;
        repeat (3) @(negedge clk);
        check("R9 hold", out_vec, held);
        check("R2 idle valid low", {511'd0, out_valid}, 512'd0);

        // R4: column limit and chunk
        cfg_colsb = 7'd20;
        request("R4 colsb 20", 32'h0000_0003);
        cfg_colsb = 7'd0;
        request("R4 colsb 0", 32'h0000_0003);
        cfg_colsb = 7'd64;
        request("R4 chunk 1", 32'h0001_0003);
        // R3: row bounds
        cfg_rows = 5'd3;
        request("R3 row equals count", 32'h0000_0003);
        cfg_rows = 5'd16;
        request("R3 row beyond array", 32'h0000_0013);

        // random mix
        void'($urandom(seed));
        for (int k = 0; k < 400; k++) begin
            int r = int'($urandom % 16);
            if ($urandom % 3 == 0) begin
                for (int i = 0; i < 16; i++) begin
                    logic [31:0] w = $urandom;
                    case ($urandom % 4)
                        0: w = w >> ($urandom % 32);
                        1: w = {w[31:8] | 24'h1, 8'h80};
                        default: ;
                    endcase
                    d[i*32 +: 32] = w;
                end
                write_row(r, d);
            end
            cfg_rows  = 5'($urandom % 17);
            cfg_colsb = 7'($urandom % 65);
            request("R3 R4 R5 R6 random",
                    {($urandom % 8 == 0) ? 16'($urandom % 3) : 16'd0,
                     16'($urandom % 18)});
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule